// File: doc/BRIEF.md
# Thirty-two pin general-purpose I/O port

This block drives and samples a bank of 32 general-purpose pins from a simple memory-mapped register bus. Software sees an output value register, a direction register and a read-only pin input register. Three write-only alias addresses change chosen output bits without a read-modify-write: one sets them, one clears them and one inverts them. Only the bits written as 1 are affected.

On the pad side the block presents a per-pin output level, a per-pin output enable and a pin level input. The input level passes through a two-flop synchroniser before software can read it. The output level always follows the output value register, whatever the direction. Software can therefore load the level first and then enable the driver, so a pin never drives a stale value.

The bus accepts one 32-bit word access per cycle when `bus_sel` is high. A write takes effect at that clock edge. A read returns its word in `bus_rdata` from the same edge.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-low reset the output value and direction registers are zero, so `pad_out` and `pad_oe` are all zero and `bus_rdata` is zero.
- R2: A write to byte offset 0x00 loads the whole output value register. `pad_out` shows the new value from the accepting edge, and a read of 0x00 returns it.
- R3: A write to offset 0x04 forces to 1 each output bit whose write-data bit is 1. The other bits keep their values.
- R4: A write to offset 0x08 forces to 0 each output bit whose write-data bit is 1. The other bits keep their values.
- R5: A write to offset 0x0C inverts each output bit whose write-data bit is 1. The other bits keep their values.
- R6: Reads of offsets 0x04, 0x08 and 0x0C return zero.
- R7: A write to offset 0x14 loads the direction register, and a read returns it. `pad_oe[i]` is 1 (driving) exactly when direction bit i is 1; a 0 makes the pin an input.
- R8: `pad_out` follows the output value register whatever the direction. A direction write leaves `pad_out` unchanged, and `pad_out` changes only on writes to offsets 0x00, 0x04, 0x08 and 0x0C.
- R9: Offset 0x10 reads the pin level through two flops. A level applied to `pad_in` before edge k first appears in read data taken at edge k+2.
- R10: Writes to 0x10, to offsets above 0x14 and to byte addresses whose two low bits are not zero change no register. Reads of those unmapped or misaligned addresses return zero.
- R11: `bus_rdata` is loaded only at an edge that accepts a read (`bus_sel`=1, `bus_we`=0). It holds its value through idle and write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Asynchronous pin levels |
| pad_out | output | 32 | Output level per pin |
| pad_oe | output | 32 | Output enable per pin (1 = drive) |

## Verification
The checker looks at every cycle and covers these rules:
- the bit-exact effect of the set, clear and toggle aliases and of direction writes on `pad_out` and `pad_oe`;
- the zero read-back of the aliases;
- that `pad_out` stays put when no output write is accepted;
- that `bus_rdata` holds between reads;
- the reset values.

Other behaviour depends on register state across several accesses, and only the bench scenarios can show it:
- the read-back of the value and direction registers;
- the two-cycle input latency, seen through reads at consecutive edges;
- that writes to the pin input register and to unmapped or misaligned addresses are ignored;
- the drive-after-load sequence.

// File: rtl/gpio_port_pkg.sv
// Shared constants and types for the GPIO port.
// Assumes word-aligned byte addressing; word indices are byte offset / 4.
package gpio_port_pkg;
    localparam int WIDX_VALUE = 0;  // 0x00
    localparam int WIDX_SET   = 1;  // 0x04
    localparam int WIDX_CLR   = 2;  // 0x08
    localparam int WIDX_TOG   = 3;  // 0x0C
    localparam int WIDX_PIN   = 4;  // 0x10
    localparam int WIDX_DIR   = 5;  // 0x14

    typedef struct packed {
        logic value;
        logic set;
        logic clr;
        logic tog;
        logic dir;
    } gpio_wr_t;

    typedef enum logic [2:0] {
        RD_ZERO,
        RD_VALUE,
        RD_PIN,
        RD_DIR
    } gpio_rd_e;
endpackage

// File: rtl/gpio_addr_dec.sv
// Address decoder: turns one bus access into write strobes and a read source.
// Assumes at most one access per cycle; misaligned addresses decode as unmapped.
module gpio_addr_dec
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output gpio_wr_t          wr,
    output logic              rd_en,
    output gpio_rd_e          rd_src
);
    localparam int IDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] widx;

    assign aligned = (addr[1:0] == 2'b00);
    assign widx    = addr[ADDR_W-1:2];
    assign rd_en   = sel && !we;

    // Write strobes: one per writable register, only for aligned writes.
    always_comb begin
        wr       = '0;
        if (sel && we && aligned) begin
            wr.value = (widx == IDX_W'(WIDX_VALUE));
            wr.set   = (widx == IDX_W'(WIDX_SET));
            wr.clr   = (widx == IDX_W'(WIDX_CLR));
            wr.tog   = (widx == IDX_W'(WIDX_TOG));
            wr.dir   = (widx == IDX_W'(WIDX_DIR));
        end
    end

    // Read source: readable registers, zero for aliases and unmapped space.
    always_comb begin
        rd_src = RD_ZERO;
        if (aligned) begin
            if (widx == IDX_W'(WIDX_VALUE))    rd_src = RD_VALUE;
            else if (widx == IDX_W'(WIDX_PIN)) rd_src = RD_PIN;
            else if (widx == IDX_W'(WIDX_DIR)) rd_src = RD_DIR;
        end
    end
endmodule

// File: rtl/gpio_out_reg.sv
// Output value register with full load and per-bit set/clear/toggle masks.
// Per bit the order applied is clear, then set, then toggle; a full load wins.
module gpio_out_reg
    import gpio_port_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  gpio_wr_t     wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic v;
        // Next value of one bit from the active strobe and its data bit.
        always_comb begin
            v = q[i];
            if (wr.clr && wdata[i]) v = 1'b0;
            if (wr.set && wdata[i]) v = 1'b1;
            if (wr.tog && wdata[i]) v = ~v;
            if (wr.value)           v = wdata[i];
            nxt[i] = v;
        end
    end

    // State update, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/gpio_sync.sv
// Multi-flop synchroniser for asynchronous pin levels.
// Assumes each pin is an independent level; no multi-bit coherence is given.
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop samples the raw pin levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= d;
            end
        end else begin : g_next
            // Later flops resolve metastability of the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
// GPIO port top: bus decode, output value and direction registers,
// synchronised pin input and registered read data.
// Assumes one bus access per cycle and a synchronous active-low reset.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe
);
    localparam int SYNC_STAGES = 2;

    gpio_wr_t     wr;
    logic         rd_en;
    gpio_rd_e     rd_src;
    logic [W-1:0] value_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pin_q;
    logic [W-1:0] rd_val;

    gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .sel    (bus_sel),
        .we     (bus_we),
        .addr   (bus_addr),
        .wr     (wr),
        .rd_en  (rd_en),
        .rd_src (rd_src)
    );

    gpio_out_reg #(.W(W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr),
        .wdata (bus_wdata),
        .q     (value_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_q)
    );

    // Direction register: 1 drives the pin, 0 leaves it an input.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr.dir) dir_q <= bus_wdata;
    end

    // Read multiplexer over the readable registers.
    always_comb begin
        case (rd_src)
            RD_VALUE: rd_val = value_q;
            RD_PIN:   rd_val = pin_q;
            RD_DIR:   rd_val = dir_q;
            default:  rd_val = '0;
        endcase
    end

    // Read data register, loaded only by an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_val;
    end

    assign pad_out = value_q;
    assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
// Port-level checker for gpio_port, attached through bind.
module gpio_port_chk #(
    parameter int W      = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_oe
);
    logic wr_any, rd_any;
    assign wr_any = bus_sel && bus_we;
    assign rd_any = bus_sel && !bus_we;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0 && pad_oe == '0 && bus_rdata == '0));

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'(8'h04)) |=>
        (pad_out == ($past(pad_out) | $past(bus_wdata))));

    // R4
    clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'(8'h08)) |=>
        (pad_out == ($past(pad_out) & ~$past(bus_wdata))));

    // R5
    toggle_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'(8'h0C)) |=>
        (pad_out == ($past(pad_out) ^ $past(bus_wdata))));

    // R6
    alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && (bus_addr == ADDR_W'(8'h04) || bus_addr == ADDR_W'(8'h08)
                    || bus_addr == ADDR_W'(8'h0C))) |=> (bus_rdata == '0));

    // R7
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'(8'h14)) |=> (pad_oe == $past(bus_wdata)));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_any && bus_addr <= ADDR_W'(8'h0C) && bus_addr[1:0] == 2'b00)
        |=> $stable(pad_out));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> $stable(bus_rdata));
endmodule

bind gpio_port gpio_port_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] model_out = '0;
    logic [31:0] model_dir = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // Driver: queue the expected word, then issue the read.
    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Monitor: after each accepted read, compare at the next falling edge.
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && bus_sel && !bus_we) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R11: unexpected read, actual %h expected none", bus_rdata);
                end else begin
                    check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(pad_out, 32'h0, "R1 pad_out");
        check(pad_oe, 32'h0, "R1 pad_oe");
        check(bus_rdata, 32'h0, "R1 rdata");
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(8'h00, 32'h0, "R1 value reg");
        bus_read(8'h14, 32'h0, "R1 dir reg");

        // R2 / R8: load value while still input, then enable the drivers
        model_out = 32'hA5A5_0F0F;
        bus_write(8'h00, model_out);
        check(pad_out, model_out, "R2 pad_out after load");
        check(pad_oe, 32'h0, "R8 no drive before dir");
        bus_read(8'h00, model_out, "R2 readback");
        model_dir = 32'hFFFF_0000;
        bus_write(8'h14, model_dir);
        check(pad_oe, model_dir, "R7 pad_oe");
        check(pad_out, model_out, "R8 level kept on dir write");
        bus_read(8'h14, model_dir, "R7 dir readback");

        // R3 set
        bus_write(8'h04, 32'h0000_00F0);
        model_out = model_out | 32'h0000_00F0;
        check(pad_out, model_out, "R3 set");
        // R4 clear
        bus_write(8'h08, 32'h0F0F_0001);
        model_out = model_out & ~32'h0F0F_0001;
        check(pad_out, model_out, "R4 clear");
        // R5 toggle, two patterns
        bus_write(8'h0C, 32'hFFFF_FFFF);
        model_out = ~model_out;
        check(pad_out, model_out, "R5 toggle all");
        bus_write(8'h0C, 32'h8000_0001);
        model_out = model_out ^ 32'h8000_0001;
        check(pad_out, model_out, "R5 toggle ends");
        bus_read(8'h00, model_out, "R5 readback");

        // R6 alias reads
        bus_read(8'h04, 32'h0, "R6 set alias read");
        bus_read(8'h08, 32'h0, "R6 clear alias read");
        bus_read(8'h0C, 32'h0, "R6 toggle alias read");

        // R9 two-flop input latency
        pad_in = 32'h1234_5678;
        bus_read(8'h10, 32'h0, "R9 edge 1 old");
        bus_read(8'h10, 32'h0, "R9 edge 2 old");
        bus_read(8'h10, 32'h1234_5678, "R9 edge 3 new");

        // R10 ignored writes and unmapped reads
        bus_write(8'h10, 32'hDEAD_BEEF);
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_write(8'h01, 32'h0000_0000);
        bus_write(8'h15, 32'h0000_0000);
        check(pad_out, model_out, "R10 pad_out untouched");
        check(pad_oe, model_dir, "R10 pad_oe untouched");
        bus_read(8'h10, 32'h1234_5678, "R10 pin reg untouched");
        bus_read(8'h18, 32'h0, "R10 unmapped read");
        bus_read(8'h02, 32'h0, "R10 misaligned read");

        // R11 read data held through idle and writes
        bus_read(8'h14, model_dir, "R11 setup");
        held = model_dir;
        repeat (3) @(negedge clk);
        check(bus_rdata, held, "R11 hold idle");
        bus_write(8'h00, 32'h0);
        model_out = 32'h0;
        check(bus_rdata, held, "R11 hold on write");
        check(pad_out, model_out, "R2 clear via load");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            tests++; fails++;
            $display("FAIL R11: pending reads actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule